// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Target

This block is the target side of a 4-bit multiplexed firmware bus that has a separate frame strobe. The host opens a transaction by raising the strobe with a start code that says whether it reads or writes. It then sends an identity nibble, a 28-bit address in seven nibbles and a size nibble. The block samples each nibble on the rising clock edge, checks the identity against strap pins and checks the size code. It then either takes one write byte or returns one read byte. It runs the bus turnaround itself and acknowledges with a sync nibble.

Address bit 22 picks the backend. When it is set, the access goes to the flash-core port. When it is clear, the access goes to the register port. Only the low 20 address bits reach the backends, or 19 bits in the half-density build. A wrong identity, an unknown start nibble or a bad size code sends the block back to idle without any bus activity. After a good header, the rest of the frame is taken as valid without further checks. A backend sees one single-cycle request per access. Read data must be valid in the same cycle as its request.

Top module: `fwb_target`

## Requirements
- R1: After reset the block drives nothing (`bus_oe_o` low) and raises no request.
- R2: A transaction begins only when `frame_i` is high while `bus_i` carries 1101 (read) or 1110 (write). Any other nibble with `frame_i` high leaves the block idle.
- R3: The identity nibble that follows the start code must equal `id_strap_i`. If it does not, the block returns to idle, raises no request and does not drive the bus.
- R4: `frame_i` high in any later cycle abandons the current transaction and is treated as a new start-code cycle. The block never drives the bus in the cycle after `frame_i` is high.
- R5: The address arrives as seven nibbles, most significant first. Bit 22 of that 28-bit address set raises `mem_req_o`. Bit 22 clear raises `reg_req_o`. The two requests are never high together.
- R6: `acc_addr_o` carries address bits 19:0 whatever the value of bits 27:20. With `HALF_DENSITY` set, bit 19 of `acc_addr_o` is forced to 0.
- R7: Only size code 0000 is accepted. Any other size returns the block to idle, with no request and no bus drive.
- R8: A write takes the data byte as two nibbles, low nibble first, then two host turnaround cycles. In the next cycle the block drives 0000 and raises a single-cycle request with `acc_we_o` high and the byte on `acc_wdata_o`.
- R9: Every drive period ends with one cycle of 1111 with `bus_oe_o` high. The next cycle has `bus_oe_o` low, and the block is then ready for a new start code.
- R10: A read raises a single-cycle request with `acc_we_o` low in the second host turnaround cycle and samples the selected read-data input there. It then drives 0000, then the low data nibble, then the high data nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame strobe from the host, active high |
| bus_i | input | 4 | Nibble bus as sampled by the target |
| id_strap_i | input | 4 | Identity strap |
| bus_o | output | 4 | Nibble driven by the target |
| bus_oe_o | output | 1 | Output enable for `bus_o` |
| mem_req_o | output | 1 | Single-cycle flash-core request |
| reg_req_o | output | 1 | Single-cycle register-space request |
| acc_we_o | output | 1 | Write flag for the current request |
| acc_addr_o | output | ADDR_W | Density-masked access address |
| acc_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Flash-core read byte, valid with `mem_req_o` |
| reg_rdata_i | input | 8 | Register read byte, valid with `reg_req_o` |

## Verification
On every cycle the assertions check the bus-drive protocol and the request rules. Each drive period opens with the 0000 sync nibble and closes after a 1111 nibble. A strobe cycle is never followed by a drive. Requests are single pulses, never to both backends at once, and a write request only comes while sync is being driven. Other behaviour can only be shown by the bench scenarios, which sweep start codes, identity values and all fifteen bad size codes. These cover address routing and masking with random-looking upper bits in both density builds, the order of the data nibbles, and recovery after a frame is aborted mid-address.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ID, ST_ADDR, ST_SIZE,
    ST_WD0, ST_WD1, ST_TI0, ST_TI1,
    ST_SYNC, ST_RD0, ST_RD1, ST_TO0, ST_TO1
  } fwb_state_e;

  localparam logic [3:0] NIB_SYNC  = 4'h0;
  localparam logic [3:0] NIB_ONES  = 4'hF;
  localparam logic [3:0] SIZE_BYTE = 4'h0;
  localparam int unsigned ADDR_NIBS = 7;
endpackage

// File: rtl/fwb_seq.sv
module fwb_seq
  import fwb_pkg::*;
#(
  parameter logic [3:0] START_RD = 4'hD,
  parameter logic [3:0] START_WR = 4'hE,
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned SEL_BIT = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [3:0]        bus_i,
  input  logic [3:0]        id_strap_i,
  input  logic [7:0]        rdata_i,
  output fwb_state_e        state_o,
  output logic              wr_o,
  output logic              acc_o,
  output logic              sel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic [7:0]        rdata_o
);
  localparam int unsigned AQ_W  = SEL_BIT + 1;
  localparam int unsigned CNT_W = $clog2(ADDR_NIBS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

  fwb_state_e       state_q, state_d;
  logic             wr_q;
  logic [AQ_W-1:0]  addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       wdata_q, rdata_q;
  logic             start_hit;

  assign start_hit = frame_i && (bus_i == START_RD || bus_i == START_WR);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: state_d = ST_IDLE;
      ST_ID:   state_d = (bus_i == id_strap_i) ? ST_ADDR : ST_IDLE;
      ST_ADDR: if (cnt_q == CNT_LAST) state_d = ST_SIZE;
      ST_SIZE: state_d = (bus_i != SIZE_BYTE) ? ST_IDLE : (wr_q ? ST_WD0 : ST_TI0);
      ST_WD0:  state_d = ST_WD1;
      ST_WD1:  state_d = ST_TI0;
      ST_TI0:  state_d = ST_TI1;
      ST_TI1:  state_d = ST_SYNC;
      ST_SYNC: state_d = wr_q ? ST_TO0 : ST_RD0;
      ST_RD0:  state_d = ST_RD1;
      ST_RD1:  state_d = ST_TO0;
      ST_TO0:  state_d = ST_TO1;
      ST_TO1:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    // strobe overrides everything: restart start-code detection
    if (frame_i) state_d = start_hit ? ST_ID : ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_hit) wr_q <= (bus_i == START_WR);
      if (state_q == ST_ID) cnt_q <= '0;
      if (state_q == ST_ADDR) begin
        addr_q <= {addr_q[AQ_W-2:0], bus_i};
        cnt_q  <= cnt_q + 1'b1;
      end
      if (state_q == ST_WD0) wdata_q[3:0] <= bus_i;
      if (state_q == ST_WD1) wdata_q[7:4] <= bus_i;
      if (state_q == ST_TI1 && !wr_q) rdata_q <= rdata_i;
    end
  end

  assign acc_o   = wr_q ? (state_q == ST_SYNC) : (state_q == ST_TI1);
  assign state_o = state_q;
  assign wr_o    = wr_q;
  assign sel_o   = addr_q[SEL_BIT];
  assign addr_o  = addr_q[ADDR_W-1:0];
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/fwb_addr_dec.sv
module fwb_addr_dec #(
  parameter bit          HALF_DENSITY = 1'b0,
  parameter int unsigned ADDR_W       = 20
) (
  input  logic              acc_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mem_req_o,
  output logic              reg_req_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned KEEP_W = HALF_DENSITY ? ADDR_W - 1 : ADDR_W;
  localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'((64'd1 << KEEP_W) - 64'd1);

  assign mem_req_o = acc_i && sel_i;
  assign reg_req_o = acc_i && !sel_i;
  assign addr_o    = addr_i & KEEP_MASK;
endmodule

// File: rtl/fwb_drive.sv
module fwb_drive
  import fwb_pkg::*;
(
  input  fwb_state_e state_i,
  input  logic [7:0] rdata_i,
  output logic [3:0] bus_o,
  output logic       bus_oe_o
);
  always_comb begin
    bus_o    = NIB_ONES;
    bus_oe_o = 1'b1;
    unique case (state_i)
      ST_SYNC: bus_o = NIB_SYNC;
      ST_RD0:  bus_o = rdata_i[3:0];
      ST_RD1:  bus_o = rdata_i[7:4];
      ST_TO0:  bus_o = NIB_ONES;
      default: bus_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fwb_target.sv
module fwb_target
  import fwb_pkg::*;
#(
  parameter bit          HALF_DENSITY = 1'b0,
  parameter int unsigned ADDR_W       = 20,
  parameter int unsigned SEL_BIT      = 22,
  parameter logic [3:0]  START_RD     = 4'hD,
  parameter logic [3:0]  START_WR     = 4'hE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [3:0]        bus_i,
  input  logic [3:0]        id_strap_i,
  output logic [3:0]        bus_o,
  output logic              bus_oe_o,
  output logic              mem_req_o,
  output logic              reg_req_o,
  output logic              acc_we_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [7:0]        acc_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic [7:0]        reg_rdata_i
);
  fwb_state_e        state;
  logic              acc, sel;
  logic [ADDR_W-1:0] raw_addr;
  logic [7:0]        rd_sel, rd_held;

  assign rd_sel = sel ? mem_rdata_i : reg_rdata_i;

  fwb_seq #(
    .START_RD(START_RD), .START_WR(START_WR),
    .ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)
  ) seq_i (
    .clk_i, .rst_ni, .frame_i, .bus_i, .id_strap_i,
    .rdata_i(rd_sel),
    .state_o(state),
    .wr_o(acc_we_o),
    .acc_o(acc),
    .sel_o(sel),
    .addr_o(raw_addr),
    .wdata_o(acc_wdata_o),
    .rdata_o(rd_held)
  );

  fwb_addr_dec #(.HALF_DENSITY(HALF_DENSITY), .ADDR_W(ADDR_W)) dec_i (
    .acc_i(acc), .sel_i(sel), .addr_i(raw_addr),
    .mem_req_o, .reg_req_o, .addr_o(acc_addr_o)
  );

  fwb_drive drv_i (
    .state_i(state), .rdata_i(rd_held), .bus_o, .bus_oe_o
  );
endmodule

// File: rtl/fwb_target_chk.sv
module fwb_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_i,
  input logic [3:0] bus_o,
  input logic       bus_oe_o,
  input logic       mem_req_o,
  input logic       reg_req_o,
  input logic       acc_we_o
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !bus_oe_o && !mem_req_o && !reg_req_o);

  a_r4_no_drive_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> !bus_oe_o);

  a_r5_one_backend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && reg_req_o));

  a_r5_mem_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r5_reg_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |=> !reg_req_o);

  a_r8_write_at_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || reg_req_o) && acc_we_o |-> bus_oe_o && bus_o == 4'h0);

  a_r9_release_after_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_oe_o) && !$past(frame_i) |-> $past(bus_o) == 4'hF);

  a_r10_drive_opens_with_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> bus_o == 4'h0);
endmodule

bind fwb_target fwb_target_chk chk_i (.*);

// File: tb/fwb_target_tb_top.sv
module fwb_target_tb_top;
  localparam logic [3:0] STRAP = 4'hC;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_i = 1'b0;
  logic [3:0] bus_i = 4'hF;
  always #2 clk_i = ~clk_i;

  logic [3:0]  f_bus, h_bus;
  logic        f_oe, h_oe, f_mreq, h_mreq, f_rreq, h_rreq, f_we, h_we;
  logic [19:0] f_addr, h_addr;
  logic [7:0]  f_wd, h_wd;

  function automatic logic [7:0] mem_model(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
  endfunction
  function automatic logic [7:0] reg_model(logic [19:0] a);
    return a[7:0] + 8'h33;
  endfunction

  fwb_target #(.HALF_DENSITY(1'b0)) dut_i (
    .clk_i, .rst_ni, .frame_i, .bus_i, .id_strap_i(STRAP),
    .bus_o(f_bus), .bus_oe_o(f_oe), .mem_req_o(f_mreq), .reg_req_o(f_rreq),
    .acc_we_o(f_we), .acc_addr_o(f_addr), .acc_wdata_o(f_wd),
    .mem_rdata_i(mem_model(f_addr)), .reg_rdata_i(reg_model(f_addr))
  );

  fwb_target #(.HALF_DENSITY(1'b1)) dut_h_i (
    .clk_i, .rst_ni, .frame_i, .bus_i, .id_strap_i(STRAP),
    .bus_o(h_bus), .bus_oe_o(h_oe), .mem_req_o(h_mreq), .reg_req_o(h_rreq),
    .acc_we_o(h_we), .acc_addr_o(h_addr), .acc_wdata_o(h_wd),
    .mem_rdata_i(mem_model(h_addr)), .reg_rdata_i(reg_model(h_addr))
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic [3:0] n);
    @(negedge clk_i);
    frame_i = f;
    bus_i   = n;
  endtask

  task automatic send_hdr(input bit wr, input logic [3:0] id,
                          input logic [27:0] a, input logic [3:0] sz);
    drive(1'b1, wr ? 4'hE : 4'hD);
    drive(1'b0, id);
    for (int i = 6; i >= 0; i--) drive(1'b0, a[i*4 +: 4]);
    drive(1'b0, sz);
  endtask

  task automatic no_resp(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      drive(1'b0, 4'hF);
      if (f_oe || h_oe || f_mreq || f_rreq || h_mreq || h_rreq) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic tail(input string req);
    @(negedge clk_i);
    chk(f_oe && h_oe && f_bus == 4'hF && h_bus == 4'hF && !f_mreq && !f_rreq,
        req, {f_oe, f_bus}, 5'h1F);
    @(negedge clk_i);
    chk(!f_oe && !h_oe, req, {f_oe, h_oe}, 0);
  endtask

  task automatic do_write(input logic [27:0] a, input logic [7:0] d);
    bit fl = a[22];
    send_hdr(1'b1, STRAP, a, 4'h0);
    drive(1'b0, d[3:0]);
    drive(1'b0, d[7:4]);
    drive(1'b0, 4'hF);
    drive(1'b0, 4'hF);
    @(negedge clk_i);
    // R8 sync cycle with write request
    chk(f_oe && f_bus == 4'h0 && f_we && f_wd == d, "R8", {f_oe, f_we, f_bus, f_wd}, {2'b11, 4'h0, d});
    chk(f_mreq == fl && f_rreq == !fl && h_mreq == fl, "R5", {f_mreq, f_rreq}, {fl, !fl});
    chk(f_addr == a[19:0], "R6", f_addr, a[19:0]);
    chk(h_addr == {1'b0, a[18:0]}, "R6", h_addr, {1'b0, a[18:0]});
    tail("R9");
  endtask

  task automatic do_read(input logic [27:0] a);
    bit fl = a[22];
    logic [7:0] ef = fl ? mem_model(a[19:0]) : reg_model(a[19:0]);
    logic [7:0] eh = fl ? mem_model({1'b0, a[18:0]}) : reg_model({1'b0, a[18:0]});
    send_hdr(1'b0, STRAP, a, 4'h0);
    drive(1'b0, 4'hF);
    drive(1'b0, 4'hF);
    chk(f_mreq == fl && f_rreq == !fl && !f_we && !f_oe, "R10", {f_mreq, f_rreq, f_we}, {fl, !fl, 1'b0});
    @(negedge clk_i);
    chk(f_oe && f_bus == 4'h0 && !f_mreq && !f_rreq, "R10", {f_oe, f_bus}, 5'h10);
    @(negedge clk_i);
    chk(f_oe && f_bus == ef[3:0] && h_bus == eh[3:0], "R10", {f_bus, h_bus}, {ef[3:0], eh[3:0]});
    @(negedge clk_i);
    chk(f_oe && f_bus == ef[7:4] && h_bus == eh[7:4], "R10", {f_bus, h_bus}, {ef[7:4], eh[7:4]});
    tail("R9");
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!f_oe && !f_mreq && !f_rreq && !h_oe, "R1", {f_oe, f_mreq, f_rreq}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!f_oe && !f_mreq && !f_rreq, "R1", {f_oe, f_mreq, f_rreq}, 0);

    // R5 R6 R8: writes with scrambled upper bits, both backends
    for (int i = 0; i < 8; i++) begin
      logic [31:0] h = 32'h9E37_79B9 * (i + 1);
      logic [27:0] a = h[27:0];
      a[22] = i[0];
      do_write(a, 8'(i * 37 + 5));
    end
    // R10: reads
    for (int i = 0; i < 8; i++) begin
      logic [31:0] h = 32'h85EB_CA6B * (i + 3);
      logic [27:0] a = h[31:4];
      a[22] = i[1];
      do_read(a);
    end
    // R7: every bad size, read and write
    for (int s = 1; s < 16; s++) begin
      send_hdr(1'b1, STRAP, 28'h0400000, 4'(s));
      no_resp(14, "R7");
      send_hdr(1'b0, STRAP, 28'h0400000, 4'(s));
      no_resp(14, "R7");
    end
    // R3: every wrong identity
    for (int id = 0; id < 16; id++) begin
      if (4'(id) != STRAP) begin
        send_hdr(1'b0, 4'(id), 28'h0412345, 4'h0);
        no_resp(14, "R3");
      end
    end
    // R2: strobe with non-start nibbles
    for (int n = 0; n < 16; n++) begin
      if (n != 13 && n != 14) begin
        drive(1'b1, 4'(n));
        drive(1'b0, STRAP);
        for (int k = 0; k < 8; k++) drive(1'b0, 4'h0);
        no_resp(6, "R2");
      end
    end
    // R4: abort mid-address, then a clean write and read
    drive(1'b1, 4'hE);
    drive(1'b0, STRAP);
    drive(1'b0, 4'h3);
    drive(1'b0, 4'h1);
    drive(1'b0, 4'h7);
    do_write(28'hFC5A5A5, 8'hA7);
    drive(1'b1, 4'hD);
    drive(1'b0, STRAP);
    drive(1'b0, 4'h0);
    do_read(28'h0BCDEF1);
    chk(!f_oe, "R4", f_oe, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule